// File: doc/BRIEF.md
# Thermal Shutdown Comparator with Hysteresis

This block watches two temperature readings, one from an on-die sensing channel and one from a remote-diode channel. Each arrives as an 8-bit unsigned whole-degree value with its own one-cycle valid strobe. Each channel is compared with its own programmable trip limit. When a reading rises strictly above the limit, that channel's over-limit flag is raised. The flag is lowered only once a later reading falls below a release level. The release level is the limit minus a shared, programmable hysteresis, floored at zero.

The over-limit flags always track temperature, whether or not a channel is enabled. A two-bit enable field selects which channels may drive the active-high system shutdown output. That output is a registered OR of the enabled over-limit flags. The block also keeps a fault register for the remote channel, which clears when it is read.

Software reaches the limits, hysteresis, enables, status and fault register through a plain register port. It uses single-cycle write and read strobes and read data registered on the following cycle.

Top module: `thsd_top`

## Requirements
- R1: After reset, both trip limits read 0x55, hysteresis reads 0x0A, the enable field, status and fault registers read 0x00, and `sys_shutdown` is low.
- R2: Register map by `reg_addr`:
  - 0 is the on-die limit (read/write).
  - 1 is the remote limit (read/write).
  - 2 is the hysteresis (read/write).
  - 3 is the enables.
  - 4 is the status (read only; bit 0 on-die over-limit, bit 1 remote over-limit).
  - 5 is the fault register.
  - 6 and 7 read 0x00, and writes to them are ignored.
  Read data appears on `reg_rdata` one cycle after `reg_rd`. A written limit takes effect for the next reading.
- R3: A strobed reading strictly greater than the channel's limit sets that channel's over-limit flag on the next cycle, whatever the enable. A reading equal to the limit does not set it.
- R4: Once set, an over-limit flag stays set while strobed readings are at or above limit minus hysteresis. It clears on the cycle after a strobed reading below that level.
- R5: When the hysteresis exceeds the limit, the release level is 0, so no reading clears the flag.
- R6: `sys_shutdown` goes high one cycle after a channel is both over-limit and enabled.
- R7: A reading presented without its channel's valid strobe changes no flag.
- R8: Clearing a channel's enable bit removes that channel's contribution from `sys_shutdown` one cycle after the write takes effect.
- R9: In the enable register, bit 0 enables the on-die channel and bit 1 enables the remote channel. Bits 7:2 always read 0.
- R10: A pulse on `ext_fault` sets bit 1 of the fault register. A read of the fault register returns 0x02 and clears it.
- R11: If `ext_fault` is high in the same cycle as a fault-register read, the read returns the prior value and bit 1 remains set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_temp | input | 8 | On-die channel reading, degrees |
| int_valid | input | 1 | Strobe for `int_temp` |
| ext_temp | input | 8 | Remote channel reading, degrees |
| ext_valid | input | 1 | Strobe for `ext_temp` |
| ext_fault | input | 1 | Remote channel diode fault event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| int_over | output | 1 | On-die over-limit flag |
| ext_over | output | 1 | Remote over-limit flag |
| sys_shutdown | output | 1 | System shutdown request, active high |

## Verification
A wrong over-limit flag shows at its own port on the cycle after the strobed reading that should have moved it. A wrong flag also shows in the status register on the next read. A wrong enable or shutdown register shows on `sys_shutdown` one cycle later. A bad release level appears only on readings that fall inside the hysteresis band, so the stimulus probes both edges of that band and the saturated case. A lost or stuck fault bit shows on the read that follows the event or the clearing read.

// File: rtl/thsd_pkg.sv
package thsd_pkg;

    localparam int TEMP_W = 8;
    localparam int ADDR_W = 3;
    localparam int NCH    = 2;
    localparam int CH_INT = 0;
    localparam int CH_EXT = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_LIM_INT = 3'd0,
        RA_LIM_EXT = 3'd1,
        RA_HYST    = 3'd2,
        RA_ENABLE  = 3'd3,
        RA_STATUS  = 3'd4,
        RA_FAULT   = 3'd5,
        RA_RSVD6   = 3'd6,
        RA_RSVD7   = 3'd7
    } reg_addr_e;

    localparam int FAULT_BIT = 1;

    typedef struct packed {
        logic [TEMP_W-1:0] lim_int;
        logic [TEMP_W-1:0] lim_ext;
        logic [TEMP_W-1:0] hyst;
        logic [NCH-1:0]    en;
    } thsd_cfg_t;

    // release level = limit - hysteresis, floored at zero
    function automatic logic [TEMP_W-1:0] release_level(
        input logic [TEMP_W-1:0] lim,
        input logic [TEMP_W-1:0] hyst
    );
        return (lim > hyst) ? (lim - hyst) : '0;
    endfunction

endpackage

// File: rtl/thsd_chan.sv
module thsd_chan
    import thsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp,
    input  logic              valid,
    input  logic [TEMP_W-1:0] limit,
    input  logic [TEMP_W-1:0] hyst,
    output logic              over
);
    logic [TEMP_W-1:0] rel_lvl;

    always_comb rel_lvl = release_level(limit, hyst);

    always_ff @(posedge clk) begin
        if (rst) begin
            over <= 1'b0;
        end else if (valid) begin
            if (temp > limit)
                over <= 1'b1;
            else if (temp < rel_lvl)
                over <= 1'b0;
        end
    end
endmodule

// File: rtl/thsd_regs.sv
module thsd_regs
    import thsd_pkg::*;
#(
    parameter logic [TEMP_W-1:0] LIM_RST  = 8'h55,
    parameter logic [TEMP_W-1:0] HYST_RST = 8'h0A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TEMP_W-1:0] wdata,
    input  logic [NCH-1:0]    status,
    input  logic              ext_fault,
    output thsd_cfg_t         cfg,
    output logic              fault_flag,
    output logic [TEMP_W-1:0] rdata
);
    reg_addr_e         ra;
    logic [TEMP_W-1:0] rd_mux;
    logic              fault_rd;

    always_comb ra = reg_addr_e'(addr);
    always_comb fault_rd = rd && (ra == RA_FAULT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.lim_int <= LIM_RST;
            cfg.lim_ext <= LIM_RST;
            cfg.hyst    <= HYST_RST;
            cfg.en      <= '0;
        end else if (wr) begin
            case (ra)
                RA_LIM_INT: cfg.lim_int <= wdata;
                RA_LIM_EXT: cfg.lim_ext <= wdata;
                RA_HYST:    cfg.hyst    <= wdata;
                RA_ENABLE:  cfg.en      <= wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    // event wins over the clearing read so no fault is lost
    always_ff @(posedge clk) begin
        if (rst)
            fault_flag <= 1'b0;
        else if (ext_fault)
            fault_flag <= 1'b1;
        else if (fault_rd)
            fault_flag <= 1'b0;
    end

    always_comb begin
        rd_mux = '0;
        case (ra)
            RA_LIM_INT: rd_mux = cfg.lim_int;
            RA_LIM_EXT: rd_mux = cfg.lim_ext;
            RA_HYST:    rd_mux = cfg.hyst;
            RA_ENABLE:  rd_mux[NCH-1:0] = cfg.en;
            RA_STATUS:  rd_mux[NCH-1:0] = status;
            RA_FAULT:   rd_mux[FAULT_BIT] = fault_flag;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/thsd_top.sv
module thsd_top
    import thsd_pkg::*;
#(
    parameter logic [TEMP_W-1:0] LIM_RST  = 8'h55,
    parameter logic [TEMP_W-1:0] HYST_RST = 8'h0A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] int_temp,
    input  logic              int_valid,
    input  logic [TEMP_W-1:0] ext_temp,
    input  logic              ext_valid,
    input  logic              ext_fault,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TEMP_W-1:0] reg_wdata,
    output logic [TEMP_W-1:0] reg_rdata,
    output logic              int_over,
    output logic              ext_over,
    output logic              sys_shutdown
);
    thsd_cfg_t         cfg_s;
    logic              fault_q;
    logic [NCH-1:0]    over_q;
    logic [TEMP_W-1:0] temp_a  [NCH];
    logic [TEMP_W-1:0] lim_a   [NCH];
    logic [NCH-1:0]    valid_a;

    always_comb begin
        temp_a[CH_INT]  = int_temp;
        temp_a[CH_EXT]  = ext_temp;
        valid_a[CH_INT] = int_valid;
        valid_a[CH_EXT] = ext_valid;
        lim_a[CH_INT]   = cfg_s.lim_int;
        lim_a[CH_EXT]   = cfg_s.lim_ext;
    end

    thsd_regs #(
        .LIM_RST (LIM_RST),
        .HYST_RST(HYST_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .status    (over_q),
        .ext_fault (ext_fault),
        .cfg       (cfg_s),
        .fault_flag(fault_q),
        .rdata     (reg_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        thsd_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .temp (temp_a[g]),
            .valid(valid_a[g]),
            .limit(lim_a[g]),
            .hyst (cfg_s.hyst),
            .over (over_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            sys_shutdown <= 1'b0;
        else
            sys_shutdown <= |(over_q & cfg_s.en);
    end

    assign int_over = over_q[CH_INT];
    assign ext_over = over_q[CH_EXT];
endmodule

// File: rtl/thsd_chk.sv
module thsd_chk
    import thsd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [TEMP_W-1:0] int_temp,
    input logic              int_valid,
    input logic [TEMP_W-1:0] ext_temp,
    input logic              ext_valid,
    input logic [TEMP_W-1:0] lim_int,
    input logic [TEMP_W-1:0] lim_ext,
    input logic [TEMP_W-1:0] hyst,
    input logic [NCH-1:0]    en,
    input logic [NCH-1:0]    over,
    input logic              shutdown,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic              ext_fault,
    input logic              fault_flag
);
    a_r3_int_trip: assert property (@(posedge clk) disable iff (rst)
        (int_valid && int_temp > lim_int) |=> over[CH_INT]);
    a_r3_ext_trip: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && ext_temp > lim_ext) |=> over[CH_EXT]);
    a_r4_int_band_hold: assert property (@(posedge clk) disable iff (rst)
        (int_valid && over[CH_INT] && int_temp >= release_level(lim_int, hyst))
        |=> over[CH_INT]);
    a_r4_ext_release: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && ext_temp < release_level(lim_ext, hyst) && ext_temp <= lim_ext)
        |=> !over[CH_EXT]);
    a_r7_int_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !int_valid |=> $stable(over[CH_INT]));
    a_r7_ext_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !ext_valid |=> $stable(over[CH_EXT]));
    a_r6_shutdown_rise: assert property (@(posedge clk) disable iff (rst)
        ((over & en) != '0) |=> shutdown);
    a_r8_shutdown_fall: assert property (@(posedge clk) disable iff (rst)
        ((over & en) == '0) |=> !shutdown);
    a_r10_fault_capture: assert property (@(posedge clk) disable iff (rst)
        ext_fault |=> fault_flag);
    a_r10_fault_clear: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == RA_FAULT && !ext_fault) |=> !fault_flag);
endmodule

bind thsd_top thsd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .int_temp  (int_temp),
    .int_valid (int_valid),
    .ext_temp  (ext_temp),
    .ext_valid (ext_valid),
    .lim_int   (cfg_s.lim_int),
    .lim_ext   (cfg_s.lim_ext),
    .hyst      (cfg_s.hyst),
    .en        (cfg_s.en),
    .over      (over_q),
    .shutdown  (sys_shutdown),
    .rd        (reg_rd),
    .addr      (reg_addr),
    .ext_fault (ext_fault),
    .fault_flag(fault_q)
);

// File: tb/sim_thsd_top.sv
`timescale 1ns/1ps
module sim_thsd_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] int_temp = '0, ext_temp = '0, reg_wdata = '0, reg_rdata;
    logic       int_valid = 1'b0, ext_valid = 1'b0, ext_fault = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       int_over, ext_over, sys_shutdown;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    logic  rd_pend = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    thsd_top u0 (
        .clk(clk), .rst(rst),
        .int_temp(int_temp), .int_valid(int_valid),
        .ext_temp(ext_temp), .ext_valid(ext_valid),
        .ext_fault(ext_fault),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_over(int_over), .ext_over(ext_over),
        .sys_shutdown(sys_shutdown)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: read data is due on the negedge after the posedge that saw reg_rd
    always @(posedge clk) rd_pend <= reg_rd;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read data with no expected item");
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic temp_in(input bit ext, input logic [7:0] v);
        @(negedge clk);
        if (ext) begin ext_temp = v; ext_valid = 1'b1; end
        else     begin int_temp = v; int_valid = 1'b1; end
        @(negedge clk);
        ext_valid = 1'b0; int_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 shutdown after reset", {7'd0, sys_shutdown}, 8'h00);
        rd_reg(3'd0, 8'h55, "R1 int limit reset");
        rd_reg(3'd1, 8'h55, "R1 ext limit reset");
        rd_reg(3'd2, 8'h0A, "R1 hysteresis reset");
        rd_reg(3'd3, 8'h00, "R1 enable reset");
        rd_reg(3'd4, 8'h00, "R1 status reset");
        rd_reg(3'd5, 8'h00, "R1 fault reset");

        wr_reg(3'd6, 8'hAA);
        rd_reg(3'd6, 8'h00, "R2 reserved address reads zero");

        temp_in(1'b0, 8'h55);
        check("R3 equal to limit no trip", {7'd0, int_over}, 8'h00);
        temp_in(1'b0, 8'h56);
        check("R3 above limit trips", {7'd0, int_over}, 8'h01);
        @(negedge clk);
        check("R3 disabled channel no shutdown", {7'd0, sys_shutdown}, 8'h00);
        rd_reg(3'd4, 8'h01, "R3 status bit while disabled");

        wr_reg(3'd3, 8'h01);
        @(negedge clk);
        check("R6 shutdown after enable", {7'd0, sys_shutdown}, 8'h01);

        temp_in(1'b0, 8'h4C);
        check("R4 inside band holds", {7'd0, int_over}, 8'h01);
        temp_in(1'b0, 8'h4B);
        check("R4 at release level holds", {7'd0, int_over}, 8'h01);
        temp_in(1'b0, 8'h4A);
        check("R4 below release clears", {7'd0, int_over}, 8'h00);
        @(negedge clk);
        check("R6 shutdown drops with flag", {7'd0, sys_shutdown}, 8'h00);

        @(negedge clk);
        int_temp = 8'hFF; ext_temp = 8'hFF;
        repeat (3) @(negedge clk);
        check("R7 no strobe int", {7'd0, int_over}, 8'h00);
        check("R7 no strobe ext", {7'd0, ext_over}, 8'h00);
        check("R7 no strobe shutdown", {7'd0, sys_shutdown}, 8'h00);

        wr_reg(3'd3, 8'h03);
        temp_in(1'b1, 8'h60);
        check("R3 ext trips", {7'd0, ext_over}, 8'h01);
        @(negedge clk);
        check("R6 ext shutdown", {7'd0, sys_shutdown}, 8'h01);
        wr_reg(3'd3, 8'h01);
        @(negedge clk);
        check("R8 disable drops shutdown", {7'd0, sys_shutdown}, 8'h00);
        check("R8 flag kept after disable", {7'd0, ext_over}, 8'h01);

        wr_reg(3'd3, 8'hFF);
        rd_reg(3'd3, 8'h03, "R9 upper enable bits read zero");
        wr_reg(3'd3, 8'h00);

        wr_reg(3'd2, 8'h60);
        temp_in(1'b1, 8'h00);
        check("R5 saturated release holds", {7'd0, ext_over}, 8'h01);
        wr_reg(3'd2, 8'h05);
        temp_in(1'b1, 8'h50);
        check("R4 ext at release holds", {7'd0, ext_over}, 8'h01);
        temp_in(1'b1, 8'h4F);
        check("R4 ext below release clears", {7'd0, ext_over}, 8'h00);

        wr_reg(3'd0, 8'h20);
        rd_reg(3'd0, 8'h20, "R2 int limit read back");
        temp_in(1'b0, 8'h21);
        check("R2 new limit applied", {7'd0, int_over}, 8'h01);
        temp_in(1'b0, 8'h00);
        check("R4 int clears at new limit", {7'd0, int_over}, 8'h00);
        rd_reg(3'd4, 8'h00, "R2 status cleared");

        @(negedge clk); ext_fault = 1'b1;
        @(negedge clk); ext_fault = 1'b0;
        rd_reg(3'd5, 8'h02, "R10 fault set");
        rd_reg(3'd5, 8'h00, "R10 fault cleared by read");

        @(negedge clk);
        exp_q.push_back(8'h00); tag_q.push_back("R11 coincident read returns prior");
        reg_rd = 1'b1; reg_addr = 3'd5; ext_fault = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; ext_fault = 1'b0;
        rd_reg(3'd5, 8'h02, "R11 fault kept through read");

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule